// File: doc/BRIEF.md
# Dual-Context Address Translation Table

This block maps virtual word addresses to physical word addresses for a processor with separate executive and user address spaces. It keeps two direct-mapped tables, one per context, each with one entry for every page of the virtual space. When paging is turned off it uses a fixed identity mapping instead. Each lookup carries a read/write flag and a flag asking for the previous context rather than the current one. The block picks a table from those flags and from the processor's mode. One cycle later it answers with one of three results: a physical address, a request that an external walker fill the entry, or a note that the address falls in the accumulator block.

The walker writes entries back through a fill port. That port names the table, the virtual page, the physical page and whether writing is allowed. Maintenance commands can clear one entry, or an even/odd pair, in both tables at once. A flush or a write to either base register clears every entry. A lookup that arrives in the same cycle as any table update is refused through a stall output and must be presented again.

Top module: `xlt_dual_ctx_tlb`

## Requirements
- R1: After reset no response is flagged, and every entry of both tables is invalid, so a paged lookup with paging on returns a fill request.
- R2: A lookup accepted at a clock edge gives `rsp_valid` high after that edge, with exactly one of `rsp_hit`, `rsp_fill`, `rsp_ac` set. On a hit, `rsp_paddr` is the entry's physical page number concatenated with the low 9 address bits.
- R3: A lookup whose selected entry is invalid returns `rsp_fill`, with `rsp_table` naming the table to fill (0 executive, 1 user).
- R4: A write lookup that meets a valid entry without write permission returns `rsp_fill`. A write to a valid, writable entry is a hit. A read of either kind of valid entry is a hit.
- R5: With paging off, every non-accumulator lookup, read or write, is a hit with `rsp_table` = 2 and `rsp_paddr` equal to the zero-extended virtual address.
- R6: Table choice: in user mode both current and previous references use the user table. In executive mode, current references use the executive table. Previous references use the user table when `prev_user` is set, and the executive table otherwise.
- R7: Addresses below 16 return `rsp_ac` with `rsp_paddr` equal to the address, whatever the paging and mode flags.
- R8: An invalidate clears the entry at `inv_vpn` in both tables. With `inv_pair` set, it clears the entries at `inv_vpn` with bit 0 forced to 0 and to 1 in both tables, and leaves other entries intact.
- R9: `flush` or `base_wr` clears every entry of both tables.
- R10: When `lk_valid` is high in a cycle with a fill, invalidate, flush or base write, `lk_stall` is high, no response follows. A lookup held until the next cycle is accepted and sees the updated table.
- R11: A fill writes only the table named by `fill_user` (0 executive, 1 user).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| paging_en | input | 1 | Paging on; when low the identity mapping is used |
| user_mode | input | 1 | Processor is in user mode |
| prev_user | input | 1 | Previous context is user (for executive-mode previous references) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 18 | Virtual word address |
| lk_write | input | 1 | Lookup is a write reference |
| lk_prev | input | 1 | Lookup uses the previous context |
| lk_stall | output | 1 | Lookup refused this cycle; present it again |
| fill_en | input | 1 | Write one table entry |
| fill_user | input | 1 | Fill target: 0 executive, 1 user |
| fill_vpn | input | 9 | Virtual page to fill |
| fill_ppn | input | 11 | Physical page number to store |
| fill_wr_ok | input | 1 | Stored entry permits writes |
| inv_en | input | 1 | Invalidate command |
| inv_vpn | input | 9 | Virtual page to invalidate |
| inv_pair | input | 1 | Invalidate the even/odd pair instead of one entry |
| flush | input | 1 | Clear both tables |
| base_wr | input | 1 | A base register was written; clears both tables |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fill | output | 1 | Walker must fill the entry |
| rsp_ac | output | 1 | Accumulator address, not translated |
| rsp_table | output | 2 | Table used: 0 executive, 1 user, 2 identity |
| rsp_paddr | output | 20 | Physical word address |

## Verification
The hardest case to reach is a lookup colliding with a table update in the same cycle. The refused lookup must produce no response, and when it is held over it must see the entry just written. The bench drives a fill and a lookup of that same page together, checks the stall and the missing response, then keeps the lookup up one more cycle and expects a hit on the new page. Pair invalidation is reached by filling three neighbouring pages across both tables and invalidating with an odd page number. Only the pair's two entries may then miss.

// File: rtl/xlt_pkg.sv
// Shared types for the dual-context translation table.
// Assumes: table identifiers are fixed 2-bit codes visible at the response port.
package xlt_pkg;

    typedef enum logic [1:0] {
        TBL_EXEC = 2'd0,
        TBL_USER = 2'd1,
        TBL_PHYS = 2'd2
    } tbl_sel_e;

endpackage

// File: rtl/xlt_page_table.sv
// One direct-mapped translation table: one entry per virtual page.
// Valid bits live in flops so a flush clears them in one cycle; the page
// number and write permission live in an unreset array.
// Assumes: when a fill and an invalidate hit the same entry in one cycle,
// the invalidate wins.
module xlt_page_table #(
    parameter int VPN_W = 9,
    parameter int PPN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_all,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             inv_pair,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_ok,
    input  logic [VPN_W-1:0] rd_vpn,
    output logic             rd_valid,
    output logic             rd_wr_ok,
    output logic [PPN_W-1:0] rd_ppn
);
    localparam int DEPTH = 1 << VPN_W;

    logic [DEPTH-1:0] vld_q;
    logic [PPN_W:0]   ent_q [DEPTH];
    logic [VPN_W-1:0] inv_even;
    logic [VPN_W-1:0] inv_odd;

    assign inv_even = {inv_vpn[VPN_W-1:1], 1'b0};
    assign inv_odd  = {inv_vpn[VPN_W-1:1], 1'b1};

    // Valid bits: reset/flush clear all, fill sets one, invalidate clears one or a pair.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            vld_q <= '0;
        end else begin
            if (wr_en) vld_q[wr_vpn] <= 1'b1;
            if (inv_en) begin
                if (inv_pair) begin
                    vld_q[inv_even] <= 1'b0;
                    vld_q[inv_odd]  <= 1'b0;
                end else begin
                    vld_q[inv_vpn] <= 1'b0;
                end
            end
        end
    end

    // Entry payload: written on fill only.
    always_ff @(posedge clk) begin
        if (wr_en) ent_q[wr_vpn] <= {wr_ok, wr_ppn};
    end

    // Read port: combinational lookup of the addressed entry.
    always_comb begin
        rd_valid = vld_q[rd_vpn];
        rd_wr_ok = ent_q[rd_vpn][PPN_W];
        rd_ppn   = ent_q[rd_vpn][PPN_W-1:0];
    end

endmodule

// File: rtl/xlt_ctx_sel.sv
// Chooses which table serves a lookup from the paging and context flags.
// Assumes: paging off overrides every context choice.
module xlt_ctx_sel
    import xlt_pkg::*;
(
    input  logic     paging_en,
    input  logic     user_mode,
    input  logic     prev_user,
    input  logic     use_prev,
    output tbl_sel_e sel
);
    // Table choice: identity when unpaged, else by mode and previous-context flag.
    always_comb begin
        if (!paging_en)                 sel = TBL_PHYS;
        else if (user_mode)             sel = TBL_USER;
        else if (use_prev && prev_user) sel = TBL_USER;
        else                            sel = TBL_EXEC;
    end
endmodule

// File: rtl/xlt_resolve.sv
// Turns the selected table entry and the access type into a result:
// accumulator bypass, hit with physical address, or fill request.
// Assumes: PPN_W >= VA_W - OFF_W so the identity map fits.
module xlt_resolve
    import xlt_pkg::*;
#(
    parameter int VA_W     = 18,
    parameter int OFF_W    = 9,
    parameter int PPN_W    = 11,
    parameter int AC_COUNT = 16
) (
    input  logic                   [VA_W-1:0]  addr,
    input  logic                               is_write,
    input  tbl_sel_e                           sel,
    input  logic                               ent_valid,
    input  logic                               ent_wr_ok,
    input  logic                   [PPN_W-1:0] ent_ppn,
    output logic                               is_ac,
    output logic                               is_hit,
    output logic                               is_fill,
    output logic [PPN_W+OFF_W-1:0]             paddr
);
    localparam int PA_W = PPN_W + OFF_W;
    localparam logic [VA_W-1:0] AC_LIM = VA_W'(AC_COUNT);

    // Classify the access and build the physical address.
    always_comb begin
        is_ac   = (addr < AC_LIM);
        is_hit  = 1'b0;
        is_fill = 1'b0;
        paddr   = {{(PA_W-VA_W){1'b0}}, addr};
        if (!is_ac) begin
            if (sel == TBL_PHYS) begin
                is_hit = 1'b1;
            end else if (ent_valid && (!is_write || ent_wr_ok)) begin
                is_hit = 1'b1;
                paddr  = {ent_ppn, addr[OFF_W-1:0]};
            end else begin
                is_fill = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlt_dual_ctx_tlb.sv
// Top: executive and user translation tables plus identity mapping,
// with a one-cycle registered response. Any table update in a cycle
// refuses a lookup in that cycle (lk_stall) so reads never race writes.
// Assumes: the requester holds a stalled lookup and presents it again.
module xlt_dual_ctx_tlb
    import xlt_pkg::*;
#(
    parameter int VA_W     = 18,
    parameter int OFF_W    = 9,
    parameter int PPN_W    = 11,
    parameter int AC_COUNT = 16,
    localparam int VPN_W   = VA_W - OFF_W,
    localparam int PA_W    = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             paging_en,
    input  logic             user_mode,
    input  logic             prev_user,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_addr,
    input  logic             lk_write,
    input  logic             lk_prev,
    output logic             lk_stall,
    input  logic             fill_en,
    input  logic             fill_user,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wr_ok,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             inv_pair,
    input  logic             flush,
    input  logic             base_wr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fill,
    output logic             rsp_ac,
    output logic [1:0]       rsp_table,
    output logic [PA_W-1:0]  rsp_paddr
);
    localparam int N_TBL = 2;

    logic             maint;
    logic             accept;
    logic             clear_all;
    logic [VPN_W-1:0] lk_vpn;
    tbl_sel_e         sel;
    logic             t_valid [N_TBL];
    logic             t_wr_ok [N_TBL];
    logic [PPN_W-1:0] t_ppn   [N_TBL];
    logic             e_valid, e_wr_ok;
    logic [PPN_W-1:0] e_ppn;
    logic             r_ac, r_hit, r_fill;
    logic [PA_W-1:0]  r_paddr;

    assign clear_all = flush | base_wr;
    assign maint     = fill_en | inv_en | clear_all;
    assign lk_stall  = lk_valid & maint;
    assign accept    = lk_valid & ~maint;
    assign lk_vpn    = lk_addr[VA_W-1:OFF_W];

    // Index 0 is the executive table, index 1 the user table.
    for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
        xlt_page_table #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_tbl (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_all(clear_all),
            .inv_en   (inv_en),
            .inv_vpn  (inv_vpn),
            .inv_pair (inv_pair),
            .wr_en    (fill_en && (fill_user == g[0])),
            .wr_vpn   (fill_vpn),
            .wr_ppn   (fill_ppn),
            .wr_ok    (fill_wr_ok),
            .rd_vpn   (lk_vpn),
            .rd_valid (t_valid[g]),
            .rd_wr_ok (t_wr_ok[g]),
            .rd_ppn   (t_ppn[g])
        );
    end

    xlt_ctx_sel u_sel (
        .paging_en(paging_en),
        .user_mode(user_mode),
        .prev_user(prev_user),
        .use_prev (lk_prev),
        .sel      (sel)
    );

    // Entry mux: pick the read port of the chosen table.
    always_comb begin
        if (sel == TBL_USER) begin
            e_valid = t_valid[1];
            e_wr_ok = t_wr_ok[1];
            e_ppn   = t_ppn[1];
        end else begin
            e_valid = t_valid[0];
            e_wr_ok = t_wr_ok[0];
            e_ppn   = t_ppn[0];
        end
    end

    xlt_resolve #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .AC_COUNT(AC_COUNT)) u_res (
        .addr     (lk_addr),
        .is_write (lk_write),
        .sel      (sel),
        .ent_valid(e_valid),
        .ent_wr_ok(e_wr_ok),
        .ent_ppn  (e_ppn),
        .is_ac    (r_ac),
        .is_hit   (r_hit),
        .is_fill  (r_fill),
        .paddr    (r_paddr)
    );

    // Response register: captures the result of an accepted lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fill  <= 1'b0;
            rsp_ac    <= 1'b0;
            rsp_table <= 2'd0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept & r_hit;
            rsp_fill  <= accept & r_fill;
            rsp_ac    <= accept & r_ac;
            if (accept) begin
                rsp_table <= sel;
                rsp_paddr <= r_paddr;
            end
        end
    end

endmodule

// File: rtl/xlt_checker.sv
// Temporal checks on the translation table's ports, bound to the top.
module xlt_checker #(
    parameter int VA_W = 18,
    parameter int PA_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            paging_en,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_addr,
    input logic            lk_stall,
    input logic            flush,
    input logic            base_wr,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_fill,
    input logic            rsp_ac,
    input logic [PA_W-1:0] rsp_paddr
);
    // R2
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_fill, rsp_ac}) == 1));

    // R2
    no_resp_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($countones({rsp_hit, rsp_fill, rsp_ac}) == 0));

    // R10
    stall_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_stall |=> !rsp_valid);

    // R7
    ac_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_stall && (lk_addr < VA_W'(16))) |=>
            (rsp_ac && rsp_paddr == {{(PA_W-VA_W){1'b0}}, $past(lk_addr)}));

    // R5
    identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_stall && !paging_en && (lk_addr >= VA_W'(16))) |=>
            (rsp_hit && rsp_paddr == {{(PA_W-VA_W){1'b0}}, $past(lk_addr)}));

    // R9
    flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ac && $past(paging_en) && $past(flush || base_wr, 2)) |-> rsp_fill);

endmodule

bind xlt_dual_ctx_tlb xlt_checker #(.VA_W(VA_W), .PA_W(PA_W)) u_xlt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .paging_en(paging_en),
    .lk_valid (lk_valid),
    .lk_addr  (lk_addr),
    .lk_stall (lk_stall),
    .flush    (flush),
    .base_wr  (base_wr),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_fill (rsp_fill),
    .rsp_ac   (rsp_ac),
    .rsp_paddr(rsp_paddr)
);

// File: tb/tb_xlt_dual_ctx_tlb.sv
module tb_xlt_dual_ctx_tlb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        paging_en, user_mode, prev_user;
    logic        lk_valid, lk_write, lk_prev;
    logic [17:0] lk_addr;
    logic        lk_stall;
    logic        fill_en, fill_user, fill_wr_ok;
    logic [8:0]  fill_vpn;
    logic [10:0] fill_ppn;
    logic        inv_en, inv_pair;
    logic [8:0]  inv_vpn;
    logic        flush, base_wr;
    logic        rsp_valid, rsp_hit, rsp_fill, rsp_ac;
    logic [1:0]  rsp_table;
    logic [19:0] rsp_paddr;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    xlt_dual_ctx_tlb dut (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .user_mode(user_mode),
        .prev_user(prev_user), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_write(lk_write), .lk_prev(lk_prev), .lk_stall(lk_stall),
        .fill_en(fill_en), .fill_user(fill_user), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_wr_ok(fill_wr_ok), .inv_en(inv_en),
        .inv_vpn(inv_vpn), .inv_pair(inv_pair), .flush(flush), .base_wr(base_wr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fill(rsp_fill),
        .rsp_ac(rsp_ac), .rsp_table(rsp_table), .rsp_paddr(rsp_paddr)
    );

    // kind: 0 hit, 1 fill request, 2 accumulator
    typedef struct packed {
        logic        pg, usr, pu, prv, wr;
        logic [17:0] addr;
        logic [1:0]  kind;
        logic [1:0]  tbl;
        logic [19:0] pa;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'h00A0A, 2'd0, 2'd0, 20'h2460A}, // exec read hit
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 18'h00A0A, 2'd0, 2'd0, 20'h2460A}, // exec write to writable
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'h00C01, 2'd0, 2'd0, 20'h08A01}, // read of read-only
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 18'h00C01, 2'd1, 2'd0, 20'h00000}, // write to read-only
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'h00E00, 2'd1, 2'd0, 20'h00000}, // invalid exec
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'h00A0A, 2'd0, 2'd1, 20'hFFE0A}, // user current
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 18'h00A0A, 2'd1, 2'd1, 20'h00000}, // user prev write RO
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 18'h013FF, 2'd0, 2'd1, 20'h401FF}, // user write last word
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'h00A0A, 2'd0, 2'd1, 20'hFFE0A}, // exec prev, prev user
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 18'h00A0A, 2'd0, 2'd0, 20'h2460A}, // exec prev, prev exec
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 18'h01200, 2'd1, 2'd0, 20'h00000}, // exec current ignores prev_user
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'h0000F, 2'd2, 2'd0, 20'h0000F}, // top accumulator
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'h00010, 2'd1, 2'd0, 20'h00000}, // first non-accumulator
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 18'h3FFFF, 2'd0, 2'd2, 20'h3FFFF}, // unpaged write, top
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 18'h00A0A, 2'd0, 2'd2, 20'h00A0A}, // unpaged read
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'h00003, 2'd2, 2'd0, 20'h00003}  // unpaged accumulator
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [17:0] a, input logic wr, input logic prv);
        lk_addr = a; lk_write = wr; lk_prev = prv; lk_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic do_fill(input logic usr, input logic [8:0] vpn, input logic [10:0] ppn, input logic ok);
        fill_en = 1'b1; fill_user = usr; fill_vpn = vpn; fill_ppn = ppn; fill_wr_ok = ok;
        @(posedge clk);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_inv(input logic [8:0] vpn, input logic pair);
        inv_en = 1'b1; inv_vpn = vpn; inv_pair = pair;
        @(posedge clk);
        @(negedge clk);
        inv_en = 1'b0; inv_pair = 1'b0;
    endtask

    task automatic set_mode(input logic pg, input logic usr, input logic pu);
        paging_en = pg; user_mode = usr; prev_user = pu;
    endtask

    // Expect a hit at pa in table tbl (R2 style check).
    task automatic expect_hit(input string req, input logic [1:0] tbl, input logic [19:0] pa);
        check(rsp_valid && rsp_hit && rsp_table == tbl && rsp_paddr == pa, req,
              {8'h0, rsp_valid, rsp_hit, rsp_table, rsp_paddr}, {8'h0, 2'b11, tbl, pa});
    endtask

    task automatic expect_fill(input string req, input logic [1:0] tbl);
        check(rsp_valid && rsp_fill && !rsp_hit && rsp_table == tbl, req,
              {28'h0, rsp_valid, rsp_fill, rsp_table}, {28'h0, 2'b11, tbl});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        set_mode(1'b1, 1'b0, 1'b0);
        lk_valid = 1'b0; lk_addr = '0; lk_write = 1'b0; lk_prev = 1'b0;
        fill_en = 1'b0; fill_user = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_wr_ok = 1'b0;
        inv_en = 1'b0; inv_vpn = '0; inv_pair = 1'b0; flush = 1'b0; base_wr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(!rsp_valid && !rsp_hit && !rsp_fill && !rsp_ac, "R1 reset outputs",
              {28'h0, rsp_valid, rsp_hit, rsp_fill, rsp_ac}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        lookup(18'h00A0A, 1'b0, 1'b0);
        expect_fill("R1 empty after reset", 2'd0);

        // Setup for the vector table; R11 fills go to the named table only
        do_fill(1'b0, 9'd5, 11'h123, 1'b1);
        do_fill(1'b0, 9'd6, 11'h045, 1'b0);
        do_fill(1'b1, 9'd5, 11'h7FF, 1'b0);
        do_fill(1'b1, 9'd9, 11'h200, 1'b1);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] k;
            logic       ok;
            set_mode(VECS[i].pg, VECS[i].usr, VECS[i].pu);
            lookup(VECS[i].addr, VECS[i].wr, VECS[i].prv);
            k = rsp_ac ? 2'd2 : (rsp_fill ? 2'd1 : (rsp_hit ? 2'd0 : 2'd3));
            ok = rsp_valid && (k == VECS[i].kind);
            if (VECS[i].kind == 2'd0) ok = ok && rsp_table == VECS[i].tbl && rsp_paddr == VECS[i].pa;
            if (VECS[i].kind == 2'd1) ok = ok && rsp_table == VECS[i].tbl;
            if (VECS[i].kind == 2'd2) ok = ok && rsp_paddr == VECS[i].pa;
            // covers R2 R3 R4 R5 R6 R7
            check(ok, $sformatf("vector %0d (R2 R3 R4 R5 R6 R7)", i),
                  {6'h0, rsp_valid, k, rsp_table, rsp_paddr}, {7'h1, VECS[i].kind, VECS[i].tbl, VECS[i].pa});
        end

        // R11: exec fill leaves user entry empty
        set_mode(1'b1, 1'b0, 1'b0);
        do_fill(1'b0, 9'd20, 11'h011, 1'b1);
        set_mode(1'b1, 1'b1, 1'b0);
        lookup({9'd20, 9'd0}, 1'b0, 1'b0);
        expect_fill("R11 other table untouched", 2'd1);

        // R8: single invalidate hits both tables, leaves neighbour
        do_inv(9'd5, 1'b0);
        set_mode(1'b1, 1'b0, 1'b0);
        lookup(18'h00A0A, 1'b0, 1'b0);
        expect_fill("R8 exec entry cleared", 2'd0);
        set_mode(1'b1, 1'b1, 1'b0);
        lookup(18'h00A0A, 1'b0, 1'b0);
        expect_fill("R8 user entry cleared", 2'd1);
        set_mode(1'b1, 1'b0, 1'b0);
        lookup(18'h00C01, 1'b0, 1'b0);
        expect_hit("R8 neighbour kept", 2'd0, 20'h08A01);

        // R8: pair invalidate with odd page 9 clears 8 and 9, keeps 10
        do_fill(1'b0, 9'd8, 11'h0F0, 1'b1);
        do_fill(1'b0, 9'd10, 11'h0F2, 1'b1);
        do_inv(9'd9, 1'b1);
        lookup({9'd8, 9'd4}, 1'b0, 1'b0);
        expect_fill("R8 pair even cleared", 2'd0);
        lookup({9'd10, 9'd4}, 1'b0, 1'b0);
        expect_hit("R8 pair outside kept", 2'd0, {11'h0F2, 9'd4});
        set_mode(1'b1, 1'b1, 1'b0);
        lookup({9'd9, 9'd4}, 1'b0, 1'b0);
        expect_fill("R8 pair odd cleared in user", 2'd1);

        // R9: flush clears everything
        set_mode(1'b1, 1'b0, 1'b0);
        lookup({9'd10, 9'd1}, 1'b0, 1'b0);
        expect_hit("R9 before flush", 2'd0, {11'h0F2, 9'd1});
        flush = 1'b1;
        @(posedge clk); @(negedge clk);
        flush = 1'b0;
        lookup({9'd10, 9'd1}, 1'b0, 1'b0);
        expect_fill("R9 flush clears", 2'd0);
        // R9: base register write clears too
        do_fill(1'b1, 9'd40, 11'h0AA, 1'b1);
        base_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        base_wr = 1'b0;
        set_mode(1'b1, 1'b1, 1'b0);
        lookup({9'd40, 9'd1}, 1'b0, 1'b0);
        expect_fill("R9 base write clears", 2'd1);

        // R10: fill and lookup collide; lookup refused then retried
        set_mode(1'b1, 1'b0, 1'b0);
        fill_en = 1'b1; fill_user = 1'b0; fill_vpn = 9'd30; fill_ppn = 11'h0AB; fill_wr_ok = 1'b1;
        lk_addr = {9'd30, 9'd0}; lk_write = 1'b0; lk_prev = 1'b0; lk_valid = 1'b1;
        #1;
        check(lk_stall == 1'b1, "R10 stall raised", {31'h0, lk_stall}, 32'h1);
        @(posedge clk); @(negedge clk);
        fill_en = 1'b0;
        check(rsp_valid == 1'b0, "R10 no response when stalled", {31'h0, rsp_valid}, 32'h0);
        @(posedge clk); @(negedge clk);
        lk_valid = 1'b0;
        expect_hit("R10 retry sees fill", 2'd0, 20'h15600);

        finish_run();
    end

endmodule